// File: doc/BRIEF.md
# Gated-Clock Timebase Counter with Prescaler

This block is a free-running timebase counter. It has two count sources, and a mode input chooses between them. In the first, a single input pin acts as a level gate on an internal tick, which fires once every eight system clocks. While the pin is high the tick passes, and while it is low the tick is blocked. In the second, the same pin acts as a slow external clock. It is brought into the system clock domain through a synchronizer and then cleaned by a digital filter, and each accepted rising edge becomes one count event.

Whichever source is selected passes through a two-bit prescaler before it reaches the counter. The prescaler divides by 1, 2, 4 or 8. A new prescaler setting is adopted only when the current division period ends. A stop input freezes the whole chain: the counter holds its value, the tick and prescaler phases are kept, and a status output reports the stopped state.

Other logic reads the counter value as a shared time reference for capture and compare functions.

Top module: `tbase_counter`

## Requirements
- R1: After reset, `count_o` is 0 and `stopped_o` is 0.
- R2: With `gate_mode`=1 and `ext_pin` held high, `count_o` advances once every 8, 16, 32 or 64 system clocks for `pre_sel` codes 0, 1, 2 and 3 (code k gives 8·2^k clocks).
- R3: With `gate_mode`=1 and `ext_pin` held low, `count_o` does not change.
- R4: With `gate_mode`=0, `count_o` advances once per 1, 2, 4 or 8 accepted rising edges of `ext_pin` for `pre_sel` codes 0, 1, 2 and 3.
- R5: In external mode, a new pin level is accepted only after the synchronized pin has held it for 3 consecutive system clocks. A high pulse or a low dip of 2 clocks or fewer produces no count event.
- R6: `count_o` only ever changes by +1, and it wraps from its all-ones value to 0.
- R7: While `stop_req` is 1, `count_o` keeps its value.
- R8: `stopped_o` equals the value `stop_req` had one clock earlier. After `stop_req` is cleared, counting resumes from the held value, so the next change is to held+1.
- R9: A new `pre_sel` value takes effect at the end of the current prescaler period. The period that is running when the code changes completes at the old ratio.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ext_pin | input | 1 | Gate level (gate mode) or external clock (external mode) |
| gate_mode | input | 1 | 1: the pin gates the divide-by-eight tick; 0: filtered pin edges count |
| pre_sel | input | 2 | Prescaler code: 0→÷1, 1→÷2, 2→÷4, 3→÷8 |
| stop_req | input | 1 | 1 freezes counting |
| count_o | output | 16 | Counter value |
| stopped_o | output | 1 | Stopped status, one clock behind `stop_req` |

## Verification
The bench measures the spacing between increments for every prescaler code in gate mode, where a wrong divider or a missing gate would show an interval other than 8·2^k clocks. It switches the code from ÷8 to ÷1 in the middle of a period; a design that adopted the code at once would produce a short first interval instead of a full 64-clock one. In external mode, the bench sends 2-clock pulses and 2-clock dips that a weak filter would count, and it counts edges over windows that are multiples of each ratio, so an off-by-one prescaler shows up as a wrong total. A narrow 8-bit instance is run through its wrap, and a stop/resume sequence checks that a design which lost its value or skipped ahead on resume is caught.

// File: rtl/tbase_pkg.sv
package tbase_pkg;

  // Count source selected by the mode input
  typedef enum logic {
    SRC_PIN_CLOCK  = 1'b0,
    SRC_GATED_TICK = 1'b1
  } src_sel_e;

endpackage

// File: rtl/tbase_rst_sync.sv
module tbase_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_s_n
);

  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q <= '0;
    end else begin
      sh_q <= sh_d;
    end
  end

  assign rst_s_n = sh_q[STAGES-1];

endmodule

// File: rtl/tbase_pin_filter.sv
module tbase_pin_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  output logic lvl_sync_o,
  output logic lvl_flt_o,
  output logic rise_o
);

  localparam int RUN_W = $clog2(FILT_LEN + 1);
  localparam logic [RUN_W-1:0] RUN_LAST = RUN_W'(FILT_LEN - 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   flt_q, flt_d;
  logic [RUN_W-1:0]       run_q, run_d;
  logic                   rise_q, rise_d;
  logic                   lvl;

  assign lvl = sync_q[SYNC_STAGES-1];

  // Accept a new level once it has differed from the held one for FILT_LEN clocks
  always_comb begin
    flt_d  = flt_q;
    run_d  = '0;
    rise_d = 1'b0;
    if (lvl != flt_q) begin
      if (run_q == RUN_LAST) begin
        flt_d  = lvl;
        rise_d = lvl;
      end else begin
        run_d = run_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      flt_q  <= 1'b0;
      run_q  <= '0;
      rise_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], pin_i};
      flt_q  <= flt_d;
      run_q  <= run_d;
      rise_q <= rise_d;
    end
  end

  assign lvl_sync_o = lvl;
  assign lvl_flt_o  = flt_q;
  assign rise_o     = rise_q;

endmodule

// File: rtl/tbase_tick_div.sv
module tbase_tick_div #(
  parameter int DIV = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  output logic tick_o
);

  localparam int DIV_W = $clog2(DIV);
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(DIV - 1);

  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic             wrap;

  assign wrap = (cnt_q == DIV_LAST);

  always_comb begin
    cnt_d = cnt_q;
    if (en_i) begin
      cnt_d = wrap ? '0 : cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign tick_o = en_i && wrap;

endmodule

// File: rtl/tbase_prescaler.sv
module tbase_prescaler #(
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic             ev_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             ev_o
);

  localparam int PC_W = (1 << SEL_W) - 1;

  logic [PC_W-1:0] pcnt_q, pcnt_d;
  logic [PC_W-1:0] lim_q, lim_d;
  logic [PC_W-1:0] lim_new;
  logic            step, term;

  // Terminal value for code k is 2^k - 1
  always_comb begin
    lim_new = '0;
    for (int i = 0; i < PC_W; i++) begin
      lim_new[i] = (i < int'(sel_i));
    end
  end

  assign step = en_i && ev_i;
  assign term = (pcnt_q == lim_q);

  always_comb begin
    pcnt_d = pcnt_q;
    lim_d  = lim_q;
    if (step) begin
      if (term) begin
        pcnt_d = '0;
        lim_d  = lim_new;
      end else begin
        pcnt_d = pcnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pcnt_q <= '0;
      lim_q  <= '0;
    end else begin
      pcnt_q <= pcnt_d;
      lim_q  <= lim_d;
    end
  end

  assign ev_o = step && term;

endmodule

// File: rtl/tbase_counter.sv
module tbase_counter
  import tbase_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SEL_W       = 2,
  parameter int GATE_DIV    = 8,
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ext_pin,
  input  logic             gate_mode,
  input  logic [SEL_W-1:0] pre_sel,
  input  logic             stop_req,
  output logic [CNT_W-1:0] count_o,
  output logic             stopped_o
);

  logic             rst_s_n;
  logic             run;
  logic             lvl_sync, flt_lvl, pin_rise;
  logic             gate_tick;
  logic             src_ev, cnt_ev;
  logic [CNT_W-1:0] count_q, count_d;
  logic             stopped_q, stopped_d;

  tbase_rst_sync #(.STAGES(2)) u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_s_n (rst_s_n)
  );

  assign run = !stop_req;

  tbase_pin_filter #(
    .SYNC_STAGES (SYNC_STAGES),
    .FILT_LEN    (FILT_LEN)
  ) u_filt (
    .clk        (clk),
    .rst_n      (rst_s_n),
    .pin_i      (ext_pin),
    .lvl_sync_o (lvl_sync),
    .lvl_flt_o  (flt_lvl),
    .rise_o     (pin_rise)
  );

  tbase_tick_div #(.DIV(GATE_DIV)) u_div (
    .clk    (clk),
    .rst_n  (rst_s_n),
    .en_i   (run),
    .tick_o (gate_tick)
  );

  always_comb begin
    case (src_sel_e'(gate_mode))
      SRC_GATED_TICK: src_ev = gate_tick && lvl_sync;
      default:        src_ev = pin_rise;
    endcase
  end

  tbase_prescaler #(.SEL_W(SEL_W)) u_pre (
    .clk   (clk),
    .rst_n (rst_s_n),
    .en_i  (run),
    .ev_i  (src_ev),
    .sel_i (pre_sel),
    .ev_o  (cnt_ev)
  );

  always_comb begin
    count_d   = cnt_ev ? count_q + 1'b1 : count_q;
    stopped_d = stop_req;
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      count_q   <= '0;
      stopped_q <= 1'b0;
    end else begin
      count_q   <= count_d;
      stopped_q <= stopped_d;
    end
  end

  assign count_o   = count_q;
  assign stopped_o = stopped_q;

endmodule

// File: rtl/tbase_counter_chk.sv
module tbase_counter_chk #(
  parameter int CNT_W    = 16,
  parameter int FILT_LEN = 3
) (
  input logic             clk,
  input logic             rst_s_n,
  input logic             stop_req,
  input logic [CNT_W-1:0] count_o,
  input logic             stopped_o,
  input logic             lvl_sync,
  input logic             flt_lvl
);

  localparam int LEN_W = $clog2(FILT_LEN + 2);
  localparam logic [LEN_W-1:0] LEN_MAX = LEN_W'(FILT_LEN + 1);

  // Consecutive clocks the synchronized pin has disagreed with the filtered level
  logic [LEN_W-1:0] diff_len;

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      diff_len <= '0;
    end else if (lvl_sync != flt_lvl) begin
      diff_len <= (diff_len == LEN_MAX) ? diff_len : diff_len + 1'b1;
    end else begin
      diff_len <= '0;
    end
  end

  a_r5_filter_len: assert property (@(posedge clk) disable iff (!rst_s_n)
    (flt_lvl != $past(flt_lvl)) |-> (diff_len >= LEN_W'(FILT_LEN)));

  a_r6_step_one: assert property (@(posedge clk) disable iff (!rst_s_n)
    (count_o != $past(count_o)) |-> (count_o == CNT_W'($past(count_o) + 1'b1)));

  a_r7_stop_hold: assert property (@(posedge clk) disable iff (!rst_s_n)
    stop_req |=> $stable(count_o));

  a_r8_flag_follows: assert property (@(posedge clk) disable iff (!rst_s_n)
    1'b1 |=> (stopped_o == $past(stop_req)));

endmodule

bind tbase_counter tbase_counter_chk #(
  .CNT_W    (CNT_W),
  .FILT_LEN (FILT_LEN)
) u_chk (
  .clk       (clk),
  .rst_s_n   (rst_s_n),
  .stop_req  (stop_req),
  .count_o   (count_o),
  .stopped_o (stopped_o),
  .lvl_sync  (lvl_sync),
  .flt_lvl   (flt_lvl)
);

// File: tb/tbase_counter_bench.sv
`timescale 1ns/1ps
module tbase_counter_bench;

  logic        clk;
  logic        rst_n;
  logic        ext_pin;
  logic        gate_mode;
  logic [1:0]  pre_sel;
  logic        stop_req;
  logic [15:0] count_o;
  logic        stopped_o;
  logic [7:0]  cnt8;
  logic        stp8;

  int n_chk;
  int n_fail;
  int cyc;
  bit done;

  tbase_counter u_tbase_counter (
    .clk(clk), .rst_n(rst_n), .ext_pin(ext_pin), .gate_mode(gate_mode),
    .pre_sel(pre_sel), .stop_req(stop_req), .count_o(count_o), .stopped_o(stopped_o)
  );

  tbase_counter #(.CNT_W(8)) u_tbase_counter_w8 (
    .clk(clk), .rst_n(rst_n), .ext_pin(ext_pin), .gate_mode(gate_mode),
    .pre_sel(pre_sel), .stop_req(stop_req), .count_o(cnt8), .stopped_o(stp8)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  initial cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wait_change(output int at);
    logic [15:0] v;
    int k;
    v = count_o;
    k = 0;
    do begin
      @(negedge clk);
      k++;
    end while (count_o == v && k < 3000);
    at = cyc;
  endtask

  task automatic pulses(input int n, input int hi, input int lo);
    for (int i = 0; i < n; i++) begin
      ext_pin = 1'b1;
      idle(hi);
      ext_pin = 1'b0;
      idle(lo);
    end
  endtask

  initial begin
    int a, b, c, v, h;
    logic [7:0] p8;
    bit wrap_seen;
    n_chk = 0; n_fail = 0; done = 0;
    rst_n = 1'b0; ext_pin = 1'b0; gate_mode = 1'b1; pre_sel = 2'd0; stop_req = 1'b0;
    idle(5);
    rst_n = 1'b1;
    idle(4);
    check(count_o == 16'd0, "R1 count after reset", count_o, 0);
    check(stopped_o == 1'b0, "R1 stopped after reset", stopped_o, 0);

    // R3: gate mode, pin low holds the count
    idle(200);
    check(count_o == 16'd0, "R3 gate low holds", count_o, 0);

    // R2: gate mode, pin high, every prescaler code
    ext_pin = 1'b1;
    for (int code = 0; code < 4; code++) begin
      pre_sel = code[1:0];
      wait_change(a);
      wait_change(b);
      wait_change(c);
      check((b - a) == (8 << code), "R2 gate interval", b - a, 8 << code);
      check((c - b) == (8 << code), "R2 gate interval repeat", c - b, 8 << code);
    end

    // R9: switch from /8 to /1 right after an increment
    wait_change(a);
    pre_sel = 2'd0;
    wait_change(b);
    wait_change(c);
    check((b - a) == 64, "R9 running period keeps old ratio", b - a, 64);
    check((c - b) == 8, "R9 new ratio after terminal", c - b, 8);

    // R6: step and wrap, watched on both widths
    wrap_seen = 0;
    p8 = cnt8;
    v = count_o;
    for (int i = 0; i < 2200; i++) begin
      @(negedge clk);
      if (cnt8 != p8) begin
        check(cnt8 == 8'(p8 + 1), "R6 narrow step", cnt8, 8'(p8 + 1));
        if (p8 == 8'hFF) begin
          wrap_seen = 1;
          check(cnt8 == 8'h00, "R6 wrap to zero", cnt8, 0);
        end
        p8 = cnt8;
      end
      if (count_o != 16'(v)) begin
        check(count_o == 16'(v + 1), "R6 wide step", count_o, 16'(v + 1));
        v = count_o;
      end
    end
    check(wrap_seen, "R6 wrap observed", wrap_seen, 1);

    // R7 / R8: stop and resume
    stop_req = 1'b1;
    @(negedge clk);
    check(stopped_o == 1'b1, "R8 flag rises one clock later", stopped_o, 1);
    h = count_o;
    idle(200);
    check(count_o == 16'(h), "R7 count frozen", count_o, h);
    check(stopped_o == 1'b1, "R8 flag held", stopped_o, 1);
    stop_req = 1'b0;
    @(negedge clk);
    check(stopped_o == 1'b0, "R8 flag clears one clock later", stopped_o, 0);
    wait_change(a);
    check(count_o == 16'(h + 1), "R8 resume from held value", count_o, 16'(h + 1));

    // R4: external mode, every code, windows that are multiples of the ratio
    gate_mode = 1'b0;
    ext_pin = 1'b0;
    idle(20);
    for (int code = 0; code < 4; code++) begin
      pre_sel = code[1:0];
      pulses(8, 4, 4);
      idle(12);
      v = count_o;
      pulses(16, 4, 4);
      idle(12);
      check(16'(count_o - v) == 16'(16 >> code), "R4 external count", 16'(count_o - v), 16 >> code);
    end

    // R5: filter, at ratio /1
    pre_sel = 2'd0;
    pulses(8, 4, 4);
    idle(12);
    v = count_o;
    pulses(5, 2, 4);
    idle(12);
    check(count_o == 16'(v), "R5 2-clock pulses ignored", count_o, v);
    pulses(5, 3, 4);
    idle(12);
    check(count_o == 16'(v + 5), "R5 3-clock pulses counted", count_o, 16'(v + 5));
    v = count_o;
    ext_pin = 1'b1;
    idle(10);
    for (int i = 0; i < 4; i++) begin
      ext_pin = 1'b0;
      idle(2);
      ext_pin = 1'b1;
      idle(5);
    end
    ext_pin = 1'b0;
    idle(12);
    check(count_o == 16'(v + 1), "R5 2-clock dips ignored", count_o, 16'(v + 1));

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 150000; i++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog completion actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule